// File: doc/BRIEF.md
# Low-frequency timer and watchdog

The block pairs a periodic reload timer with a watchdog that is clocked from the timer's output. A slow time base arrives as a one-cycle `tick_i` enable in the system clock domain. A programmable power-of-two prescaler divides the ticks and steps a 16-bit down-counter. Each time that counter wraps, it emits a one-cycle timer event on `timer_evt_o`. A second prescaler takes either that event or the raw tick and steps an 8-bit watchdog down-counter. When the watchdog counter expires, the block pulses `wd_reset_o`.

Software uses a byte-wide register bus with a write strobe and a combinational read port. Writing the watchdog count register starts the watchdog. Writing a key byte to the service register reloads the count. A fixed three-byte key sequence on the same register stops the watchdog and clears the lock bits. Software can lock the configuration, timer prescaler, timer reload and watchdog count registers against stray writes. Only reset or the stop sequence removes a lock.

Top module: `lf_timer_wdog`

## Requirements
- R1: After reset, these registers read as follows: configuration 0x00 reads 0x00, reload 0x04/0x05 reads 0xFF/0xFF, control 0x06 reads 0x00, watchdog reload 0x08 reads 0xFF, live watchdog count 0x0E reads 0xFF. The watchdog is not running.
- R2: Timer prescaler 0x02 bits [2:0] = n divides `tick_i` by 2^n. The timer counts down from its reload value (low byte 0x04, high byte 0x05). It pulses `timer_evt_o` for one cycle every (reload+1)*2^n ticks.
- R3: Writing 1 to control bit 0 (register 0x06) requests a timer restart. The bit reads 1 for exactly one cycle, during which the timer count and its prescaler are reloaded. After that it reads 0.
- R4: Configuration bit 4 (register 0x00) selects the watchdog clock: 1 = timer event, 0 = `tick_i`. Watchdog prescaler 0x10 bits [2:0] = m divides that source by 2^m. Writing register 0x08 loads both the reload value and the count, and sets the running flag (control bit 5).
- R5: A running watchdog whose count is 0 when a prescaled step arrives pulses `wd_reset_o` for one cycle and reloads the count. One cycle later it sets the sticky flag at control bit 4. Writing 1 to control bit 4 clears the flag.
- R6: Writing 0x5C to service register 0x0A reloads the watchdog count only while configuration bit 5 is 1. With bit 5 at 0 the write has no effect and the watchdog still expires.
- R7: Writing 0x87, 0x61, 0x63 in that order to 0x0A stops the watchdog (bit 5 reads 0) and clears all lock bits. A 0x5C write does not disturb the sequence. Any other non-matching byte, including a repeated 0x87, returns detection to the start.
- R8: Configuration bits 0..3 lock, in that order, the configuration, timer prescaler, timer reload (both bytes) and watchdog count registers. A locked register keeps its value on writes. Lock bits are set by writing 1 and are not cleared by writing 0. The watchdog prescaler has no lock.
- R9: The following registers only report state, and writes to them have no effect:
  - the live timer count (0x0C low, 0x0D high);
  - the live watchdog count (0x0E);
  - the running flag (control bit 5).
  Control bit 7 is a stored read/write bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable carrying the slow time base |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| timer_evt_o | output | 1 | One-cycle timer wrap event |
| wd_reset_o | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The timer is run with a continuous tick and with a tick present every other cycle. Counting events over a fixed window with each pattern separates the tick-count prescaler from a cycle-count one. The watchdog is run in three ways:
- clocked from timer events, serviced faster than its timeout, which must give no expiry;
- clocked from timer events with servicing disabled, which must still expire;
- clocked from the raw tick, where the exact expiry count in a window pins down the (reload+1) step period.

Key sequences are sent intact, interleaved with the service key, broken by a foreign byte and broken by a repeated first byte, which tells apart restart-on-mismatch from partial matching.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned TMR_W  = 16;
  localparam int unsigned WD_W   = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned LOCK_N = 4;

  localparam logic [ADDR_W-1:0] A_CFG     = 5'h00;
  localparam logic [ADDR_W-1:0] A_TPRE    = 5'h02;
  localparam logic [ADDR_W-1:0] A_RLD_LO  = 5'h04;
  localparam logic [ADDR_W-1:0] A_RLD_HI  = 5'h05;
  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h06;
  localparam logic [ADDR_W-1:0] A_WDLD    = 5'h08;
  localparam logic [ADDR_W-1:0] A_SVC     = 5'h0A;
  localparam logic [ADDR_W-1:0] A_TCNT_LO = 5'h0C;
  localparam logic [ADDR_W-1:0] A_TCNT_HI = 5'h0D;
  localparam logic [ADDR_W-1:0] A_WDCNT   = 5'h0E;
  localparam logic [ADDR_W-1:0] A_WPRE    = 5'h10;

  localparam logic [7:0] KEY_SVC   = 8'h5C;
  localparam logic [7:0] KEY_STOP0 = 8'h87;
  localparam logic [7:0] KEY_STOP1 = 8'h61;
  localparam logic [7:0] KEY_STOP2 = 8'h63;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_GOT0, SEQ_GOT1} seq_e;
endpackage

// File: rtl/twd_prescaler.sv
module twd_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  assign mask   = ~({CNT_W{1'b1}} << sel_i);
  assign step_o = src_i && (cnt_q >= mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (src_i)  cnt_q <= step_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/twd_timer.sv
module twd_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [TMR_W-1:0] reload_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '1;
      evt_o <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (restart_i) begin
        cnt_o <= reload_i;
      end else if (step_i) begin
        if (cnt_o == '0) begin
          cnt_o <= reload_i;
          evt_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/twd_wdog.sv
module twd_wdog #(
  parameter int unsigned WD_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WD_W-1:0] load_val_i,
  input  logic            svc_i,
  input  logic            stop_i,
  input  logic            step_i,
  input  logic [WD_W-1:0] reload_i,
  output logic [WD_W-1:0] cnt_o,
  output logic            run_o,
  output logic            expire_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '1;
      run_o    <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (load_i) begin
        cnt_o <= load_val_i;
        run_o <= 1'b1;
      end else if (svc_i) begin
        cnt_o <= reload_i;
      end else if (stop_i) begin
        run_o <= 1'b0;
      end else if (run_o && step_i) begin
        if (cnt_o == '0) begin
          cnt_o    <= reload_i;
          expire_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/twd_keydec.sv
module twd_keydec
  import twd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  input  logic       svc_en_i,
  output logic       svc_o,
  output logic       stop_o
);
  seq_e seq_q, seq_d;

  assign svc_o  = wr_i && (data_i == KEY_SVC) && svc_en_i;
  assign stop_o = wr_i && (seq_q == SEQ_GOT1) && (data_i == KEY_STOP2);

  always_comb begin
    seq_d = seq_q;
    if (wr_i && data_i != KEY_SVC) begin
      // any byte off the expected path restarts detection
      if (seq_q == SEQ_IDLE && data_i == KEY_STOP0)      seq_d = SEQ_GOT0;
      else if (seq_q == SEQ_GOT0 && data_i == KEY_STOP1) seq_d = SEQ_GOT1;
      else                                               seq_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seq_q <= SEQ_IDLE;
    else         seq_q <= seq_d;
  end
endmodule

// File: rtl/lf_timer_wdog.sv
module lf_timer_wdog
  import twd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              timer_evt_o,
  output logic              wd_reset_o
);
  localparam int unsigned PAD_W = 8 - SEL_W;

  logic [LOCK_N-1:0] lock_q;
  logic              src_sel_q, svc_en_q;
  logic [SEL_W-1:0]  tpre_q, wpre_q;
  logic [TMR_W-1:0]  reload_q, tcnt;
  logic              restart_q, early_dis_q, wd_flag_q;
  logic [WD_W-1:0]   wd_reload_q, wd_cnt;
  logic              wd_run, wd_exp, tstep, wstep, wsrc;
  logic              svc_hit, stop_done, wd_load;
  logic              wr_cfg, wr_tpre, wr_rlo, wr_rhi, wr_ctrl, wr_wdld, wr_svc, wr_wpre;

  assign wr_cfg  = wr_en_i && addr_i == A_CFG;
  assign wr_tpre = wr_en_i && addr_i == A_TPRE;
  assign wr_rlo  = wr_en_i && addr_i == A_RLD_LO;
  assign wr_rhi  = wr_en_i && addr_i == A_RLD_HI;
  assign wr_ctrl = wr_en_i && addr_i == A_CTRL;
  assign wr_wdld = wr_en_i && addr_i == A_WDLD;
  assign wr_svc  = wr_en_i && addr_i == A_SVC;
  assign wr_wpre = wr_en_i && addr_i == A_WPRE;
  assign wd_load = wr_wdld && !lock_q[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q      <= '0;
      src_sel_q   <= 1'b0;
      svc_en_q    <= 1'b0;
      tpre_q      <= '0;
      wpre_q      <= '0;
      reload_q    <= '1;
      wd_reload_q <= '1;
      restart_q   <= 1'b0;
      early_dis_q <= 1'b0;
      wd_flag_q   <= 1'b0;
    end else begin
      if (stop_done) begin
        lock_q <= '0;
      end else if (wr_cfg && !lock_q[0]) begin
        lock_q    <= lock_q | wdata_i[LOCK_N-1:0];
        src_sel_q <= wdata_i[4];
        svc_en_q  <= wdata_i[5];
      end
      if (wr_tpre && !lock_q[1]) tpre_q <= wdata_i[SEL_W-1:0];
      if (wr_rlo && !lock_q[2])  reload_q[7:0] <= wdata_i;
      if (wr_rhi && !lock_q[2])  reload_q[TMR_W-1:8] <= wdata_i[TMR_W-9:0];
      if (wd_load)               wd_reload_q <= wdata_i[WD_W-1:0];
      if (wr_wpre)               wpre_q <= wdata_i[SEL_W-1:0];
      restart_q <= wr_ctrl && wdata_i[0];
      if (wr_ctrl) early_dis_q <= wdata_i[7];
      if (wd_exp)                      wd_flag_q <= 1'b1;
      else if (wr_ctrl && wdata_i[4])  wd_flag_q <= 1'b0;
    end
  end

  twd_prescaler #(.SEL_W(SEL_W)) u_tpre (
    .clk_i, .rst_ni, .clr_i(restart_q), .src_i(tick_i), .sel_i(tpre_q), .step_o(tstep)
  );

  twd_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .restart_i(restart_q), .step_i(tstep), .reload_i(reload_q),
    .cnt_o(tcnt), .evt_o(timer_evt_o)
  );

  assign wsrc = src_sel_q ? timer_evt_o : tick_i;

  twd_prescaler #(.SEL_W(SEL_W)) u_wpre (
    .clk_i, .rst_ni, .clr_i(wd_load || svc_hit || !wd_run), .src_i(wsrc),
    .sel_i(wpre_q), .step_o(wstep)
  );

  twd_keydec u_keys (
    .clk_i, .rst_ni, .wr_i(wr_svc), .data_i(wdata_i), .svc_en_i(svc_en_q),
    .svc_o(svc_hit), .stop_o(stop_done)
  );

  twd_wdog #(.WD_W(WD_W)) u_wdog (
    .clk_i, .rst_ni, .load_i(wd_load), .load_val_i(wdata_i[WD_W-1:0]), .svc_i(svc_hit),
    .stop_i(stop_done), .step_i(wstep), .reload_i(wd_reload_q),
    .cnt_o(wd_cnt), .run_o(wd_run), .expire_o(wd_exp)
  );

  assign wd_reset_o = wd_exp;

  always_comb begin
    unique case (addr_i)
      A_CFG:     rdata_o = {2'b00, svc_en_q, src_sel_q, lock_q};
      A_TPRE:    rdata_o = {{PAD_W{1'b0}}, tpre_q};
      A_RLD_LO:  rdata_o = reload_q[7:0];
      A_RLD_HI:  rdata_o = reload_q[TMR_W-1:8];
      A_CTRL:    rdata_o = {early_dis_q, 1'b0, wd_run, wd_flag_q, 3'b000, restart_q};
      A_WDLD:    rdata_o = wd_reload_q;
      A_TCNT_LO: rdata_o = tcnt[7:0];
      A_TCNT_HI: rdata_o = tcnt[TMR_W-1:8];
      A_WDCNT:   rdata_o = wd_cnt;
      A_WPRE:    rdata_o = {{PAD_W{1'b0}}, wpre_q};
      default:   rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/lf_timer_wdog_chk.sv
module lf_timer_wdog_chk
  import twd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              timer_evt_o,
  input logic              wd_reset_o,
  input logic [TMR_W-1:0]  tcnt_i,
  input logic [TMR_W-1:0]  reload_i,
  input logic              run_i,
  input logic              flag_i,
  input logic              stop_i,
  input logic [LOCK_N-1:0] lock_i,
  input logic              restart_i,
  input logic              ctrl_wr_i
);
  p_evt_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_evt_o && $stable(reload_i) |-> tcnt_i == reload_i);

  p_restart_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i && !ctrl_wr_i |=> !restart_i);

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !wd_reset_o);

  p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_reset_o |=> flag_i);

  p_stop_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_i && lock_i == '0);

  p_lock_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(lock_i) & ~lock_i)) |-> $past(stop_i));
endmodule

bind lf_timer_wdog lf_timer_wdog_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .timer_evt_o(timer_evt_o), .wd_reset_o(wd_reset_o),
  .tcnt_i(tcnt), .reload_i(reload_q), .run_i(wd_run), .flag_i(wd_flag_q),
  .stop_i(stop_done), .lock_i(lock_q), .restart_i(restart_q), .ctrl_wr_i(wr_ctrl)
);

// File: tb/lf_timer_wdog_tb.sv
module lf_timer_wdog_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tevt, wrst;

  always #4 clk = ~clk;

  lf_timer_wdog u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .timer_evt_o(tevt), .wd_reset_o(wrst)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  int m_lock, m_src, m_sven, m_tpre, m_rld, m_rq, m_early, m_flag, m_wpre, m_wdrld;
  int m_tpc, m_tcnt, m_tevt, m_wpc, m_wcnt, m_run, m_wexp, m_seq;

  function automatic int m_read(input int a);
    case (a)
      0:  return (m_sven << 5) | (m_src << 4) | m_lock;
      2:  return m_tpre;
      4:  return m_rld & 255;
      5:  return (m_rld >> 8) & 255;
      6:  return (m_early << 7) | (m_run << 5) | (m_flag << 4) | m_rq;
      8:  return m_wdrld;
      12: return m_tcnt & 255;
      13: return (m_tcnt >> 8) & 255;
      14: return m_wcnt;
      16: return m_wpre;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int a, d, tk, tstep, wsrc, wstep, svc, stop, wload;
    int n_tpc, n_tcnt, n_tevt, n_wpc, n_wcnt, n_run, n_wexp, n_seq;
    if (!rst_n) begin
      m_lock = 0; m_src = 0; m_sven = 0; m_tpre = 0; m_rld = 16'hFFFF; m_rq = 0;
      m_early = 0; m_flag = 0; m_wpre = 0; m_wdrld = 255; m_tpc = 0; m_tcnt = 16'hFFFF;
      m_tevt = 0; m_wpc = 0; m_wcnt = 255; m_run = 0; m_wexp = 0; m_seq = 0;
    end else begin
      a = we ? int'(addr) : -1;
      d = int'(wdata);
      tk = int'(tick);
      tstep = (tk != 0 && m_tpc >= (1 << m_tpre) - 1) ? 1 : 0;
      wsrc = (m_src != 0) ? m_tevt : tk;
      wstep = (wsrc != 0 && m_wpc >= (1 << m_wpre) - 1) ? 1 : 0;
      svc = (a == 10 && d == 'h5C && m_sven != 0) ? 1 : 0;
      stop = (a == 10 && m_seq == 2 && d == 'h63) ? 1 : 0;
      wload = (a == 8 && (m_lock & 8) == 0) ? 1 : 0;

      n_tpc = (m_rq != 0) ? 0 : (tk != 0) ? ((tstep != 0) ? 0 : m_tpc + 1) : m_tpc;
      n_tcnt = m_tcnt; n_tevt = 0;
      if (m_rq != 0) n_tcnt = m_rld;
      else if (tstep != 0) begin
        if (m_tcnt == 0) begin n_tcnt = m_rld; n_tevt = 1; end
        else n_tcnt = m_tcnt - 1;
      end

      n_wpc = (wload != 0 || svc != 0 || m_run == 0) ? 0 :
              (wsrc != 0) ? ((wstep != 0) ? 0 : m_wpc + 1) : m_wpc;
      n_wcnt = m_wcnt; n_run = m_run; n_wexp = 0;
      if (wload != 0) begin n_wcnt = d; n_run = 1; end
      else if (svc != 0) n_wcnt = m_wdrld;
      else if (stop != 0) n_run = 0;
      else if (m_run != 0 && wstep != 0) begin
        if (m_wcnt == 0) begin n_wcnt = m_wdrld; n_wexp = 1; end
        else n_wcnt = m_wcnt - 1;
      end

      n_seq = m_seq;
      if (a == 10 && d != 'h5C)
        n_seq = (m_seq == 0 && d == 'h87) ? 1 : (m_seq == 1 && d == 'h61) ? 2 : 0;

      if (m_wexp != 0) m_flag = 1;
      else if (a == 6 && (d & 16) != 0) m_flag = 0;
      m_rq = (a == 6) ? (d & 1) : 0;
      if (a == 6) m_early = (d >> 7) & 1;
      if (stop != 0) m_lock = 0;
      else if (a == 0 && (m_lock & 1) == 0) begin
        m_lock = m_lock | (d & 15); m_src = (d >> 4) & 1; m_sven = (d >> 5) & 1;
      end
      if (a == 2 && (m_lock & 2) == 0) m_tpre = d & 7;
      if (a == 4 && (m_lock & 4) == 0) m_rld = (m_rld & 'hFF00) | d;
      if (a == 5 && (m_lock & 4) == 0) m_rld = (m_rld & 'h00FF) | (d << 8);
      if (wload != 0) m_wdrld = d;
      if (a == 16) m_wpre = d & 7;
      m_tpc = n_tpc; m_tcnt = n_tcnt; m_tevt = n_tevt; m_wpc = n_wpc;
      m_wcnt = n_wcnt; m_run = n_run; m_wexp = n_wexp; m_seq = n_seq;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (int'(rdata) != m_read(int'(addr)) || int'(tevt) != m_tevt || int'(wrst) != m_wexp) begin
        n_bad++;
        $display("FAIL %s: addr 0x%0h rdata 0x%0h evt %0d rst %0d expected 0x%0h %0d %0d",
                 cur_req, addr, rdata, tevt, wrst, m_read(int'(addr)), m_tevt, m_wexp);
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    we = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic rdv(input int a, output int v);
    addr = 5'(a);
    @(negedge clk);
    v = int'(rdata);
    @(posedge clk); #2;
  endtask

  task automatic rdc(input string tag, input int a, input int exp);
    int v;
    rdv(a, v);
    chk(tag, v, exp);
  endtask

  task automatic rdbit(input string tag, input int a, input int b, input int exp);
    int v;
    rdv(a, v);
    chk(tag, (v >> b) & 1, exp);
  endtask

  // run n cycles, optional service every svc_per cycles, optional tick toggling
  task automatic window(input int n, input int svc_per, input bit toggle,
                        output int ev, output int rs);
    ev = 0; rs = 0;
    for (int i = 0; i < n; i++) begin
      if (toggle) tick = ~tick;
      if (svc_per > 0 && i % svc_per == 0) begin
        we = 1'b1; addr = 5'h0A; wdata = 8'h5C;
      end else begin
        we = 1'b0;
      end
      @(negedge clk);
      ev += int'(tevt);
      rs += int'(wrst);
      @(posedge clk); #2;
    end
    we = 1'b0;
  endtask

  task automatic stop_seq();
    wr('h0A, 'h87); wr('h0A, 'h61); wr('h0A, 'h63);
  endtask

  initial begin
    int ev, rs, v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;

    cur_req = "R1";
    rdc("R1 cfg", 'h00, 'h00);
    rdc("R1 reload lo", 'h04, 'hFF);
    rdc("R1 reload hi", 'h05, 'hFF);
    rdc("R1 ctrl", 'h06, 'h00);
    rdc("R1 wd reload", 'h08, 'hFF);
    rdc("R1 wd count", 'h0E, 'hFF);

    cur_req = "R2";
    tick = 1'b1;
    wr('h02, 2); wr('h04, 3); wr('h05, 0);
    cur_req = "R3";
    wr('h06, 1);
    rdbit("R3 restart bit set", 'h06, 0, 1);
    rdbit("R3 restart bit cleared", 'h06, 0, 0);
    rdc("R3 count reloaded", 'h0D, 0);
    cur_req = "R2";
    window(160, 0, 1'b0, ev, rs);
    chk("R2 events continuous tick", ev, 10);
    window(320, 0, 1'b1, ev, rs);
    chk("R2 events gated tick", ev, 10);
    tick = 1'b1;

    cur_req = "R4";
    wr('h00, 'h30); wr('h10, 1); wr('h08, 2);
    rdbit("R4 running after load", 'h06, 5, 1);
    cur_req = "R5";
    window(130, 0, 1'b0, ev, rs);
    chk("R5 one expiry", rs, 1);
    rdbit("R5 sticky flag set", 'h06, 4, 1);
    wr('h06, 'h10);
    rdbit("R5 sticky flag cleared", 'h06, 4, 0);

    cur_req = "R6";
    window(400, 40, 1'b0, ev, rs);
    chk("R6 serviced no expiry", rs, 0);
    wr('h00, 'h10);
    window(300, 40, 1'b0, ev, rs);
    chk("R6 key ignored when disabled", int'(rs > 0), 1);

    cur_req = "R4";
    wr('h00, 'h20); wr('h10, 0); wr('h08, 5);
    window(61, 0, 1'b0, ev, rs);
    chk("R4 tick source expiry count", rs, 10);

    cur_req = "R7";
    wr('h0A, 'h87); wr('h0A, 'h61); wr('h0A, 'h5C); wr('h0A, 'h63);
    rdbit("R7 stopped with key interleaved", 'h06, 5, 0);
    wr('h08, 'h40);
    wr('h0A, 'h87); wr('h0A, 'h00); wr('h0A, 'h61); wr('h0A, 'h63);
    rdbit("R7 foreign byte breaks sequence", 'h06, 5, 1);
    wr('h0A, 'h87); wr('h0A, 'h87); wr('h0A, 'h61); wr('h0A, 'h63);
    rdbit("R7 repeated first byte breaks sequence", 'h06, 5, 1);
    stop_seq();
    rdbit("R7 clean sequence stops", 'h06, 5, 0);

    cur_req = "R8";
    wr('h00, 'h2F);
    rdc("R8 cfg locked", 'h00, 'h2F);
    wr('h02, 5);
    rdc("R8 timer prescaler held", 'h02, 2);
    wr('h04, 'h55);
    rdc("R8 reload held", 'h04, 3);
    wr('h08, 'h33);
    rdc("R8 wd reload held", 'h08, 'h40);
    rdbit("R8 locked load does not start", 'h06, 5, 0);
    wr('h00, 'h00);
    rdc("R8 locks survive zero write", 'h00, 'h2F);
    wr('h10, 3);
    rdc("R8 wd prescaler not lockable", 'h10, 3);
    stop_seq();
    rdc("R8 locks released", 'h00, 'h20);
    wr('h02, 1);
    rdc("R8 prescaler writable again", 'h02, 1);

    cur_req = "R9";
    wr('h06, 'hA0);
    rdbit("R9 running flag read-only", 'h06, 5, 0);
    rdbit("R9 bit7 stored", 'h06, 7, 1);
    rdv('h0E, v);
    wr('h0E, (v + 1) & 255);
    rdc("R9 live wd count not writable", 'h0E, v);
    wr('h0D, 'h7F);
    rdc("R9 live timer high byte", 'h0D, 0);
    window(20, 0, 1'b0, ev, rs);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule